// File: doc/BRIEF.md
# Presettable BCD Up/Down Counter

A single decimal digit counter held in four bits. On each rising clock edge it steps one code up or down, as the direction select chooses, provided the active-low count-enable (carry input) is low. A parallel load port puts any four-bit value into the digit. A clear input forces the digit to zero, and clear takes priority over load, which takes priority over counting. An active-low carry output marks the terminal count of the current direction, so several digits that share one clock can be chained into a synchronous multi-digit counter. To chain them, drive each digit's carry input from the carry output of the digit below it.

Codes 10 to 15 are not decimal digits. They can only enter through the load port. From any of them the counter gets back to a decimal digit within two clocks when counting up and within four when counting down. Each such code follows a fixed path back.

Clear and load both act on the clock edge. Clear is the project's synchronous active-low reset. Load overrides both the count-enable and the direction.

Top module: `bcd_updown_counter`

## Requirements
- R1: With `clr_n` high, `load` low and `cin_n` high, a clock edge leaves `q` unchanged.
- R2: With `clr_n` high, `load` low, `cin_n` low and `up` high, each edge moves `q` from 0..8 to the next value and from 9 to 0. `q[0]` is the least significant bit.
- R3: With `clr_n` high, `load` low, `cin_n` low and `up` low, each edge moves `q` from 1..9 to the value one lower and from 0 to 9.
- R4: `clr_n` low at an edge sets `q` to 0, whatever the values of `load`, `jam`, `up` and `cin_n`.
- R5: `load` high with `clr_n` high at an edge copies `jam` into `q`, whatever the values of `cin_n` and `up`.
- R6: Counting up from a code above 9, an even code steps to the next code and an odd code steps to 0. This gives 10→11, 11→0, 12→13, 13→0, 14→15 and 15→0, so a decimal digit is reached within 2 edges.
- R7: Counting down from a code above 9, the steps are 15→13, 14→12, 13→11, 12→10, 11→9 and 10→9, so a decimal digit is reached within 4 edges.
- R8: `cout_n` is combinational. It is 0 exactly when `cin_n` is 0 and `q` is 9 with `up` high, or `q` is 0 with `up` low. In every other case it is 1.
- R9: When two counters share the clock and the upper digit's `cin_n` is the lower digit's `cout_n`, the pair counts as a two-digit decimal number in both directions. This includes the step from 00 down to 99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr_n | input | 1 | Synchronous active-low clear, highest priority |
| load | input | 1 | Parallel load enable, active high |
| jam | input | 4 | Parallel load value |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| cin_n | input | 1 | Active-low count enable (carry in) |
| q | output | 4 | Current digit, bit 0 least significant |
| cout_n | output | 1 | Active-low terminal-count carry out |

## Verification
The three actions on the register can be requested in the same cycle, so the bench checks their priority. First it holds `clr_n` low while `load` is high with a nonzero `jam` and `cin_n` is low; the digit must read 0 after the edge. Next it raises `load` while counting is enabled in both directions, and the loaded value must win over the count. Finally it raises `load` while `cin_n` is high, and the load must still happen. The carry output is sampled in the same settle window as each count step, which confirms that the terminal flag and the wrap it predicts occur on the same edge.

// File: rtl/bcd_cnt_pkg.sv
// Shared definitions for the BCD counter: the action selected per edge.
package bcd_cnt_pkg;
    // Register action for one clock edge, in priority order.
    typedef enum logic [1:0] {
        ACT_CLEAR = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_COUNT = 2'd2,
        ACT_HOLD  = 2'd3
    } act_e;
endpackage

// File: rtl/bcd_act_sel.sv
// Picks the register action from the control pins.
// Assumes all controls are synchronous to the counter clock.
module bcd_act_sel
    import bcd_cnt_pkg::*;
(
    input  logic clr_n,
    input  logic load,
    input  logic cin_n,
    output act_e act
);
    // Priority: clear, then load, then count, else hold.
    always_comb begin
        if (!clr_n)      act = ACT_CLEAR;
        else if (load)   act = ACT_LOAD;
        else if (!cin_n) act = ACT_COUNT;
        else             act = ACT_HOLD;
    end
endmodule

// File: rtl/bcd_step.sv
// Next-code function for one counting step in either direction.
// Codes above TOP_CODE are steered back to the legal range.
// Assumes TOP_CODE + 1 < 2**W.
module bcd_step #(
    parameter int W        = 4,
    parameter int TOP_CODE = 9
) (
    input  logic [W-1:0] cur,
    input  logic         up,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] TOP_C   = W'(TOP_CODE);
    localparam logic [W-1:0] FIRST_X = W'(TOP_CODE + 1);
    localparam logic [W-1:0] ONE     = W'(1);
    localparam logic [W-1:0] TWO     = W'(2);

    // Up: increment with wrap; illegal even codes step up, odd ones fall to 0.
    // Down: decrement with wrap; the lowest illegal code lands on TOP,
    // the other illegal codes drop by two.
    always_comb begin
        if (up) begin
            if (cur == TOP_C)     nxt = '0;
            else if (cur < TOP_C) nxt = cur + ONE;
            else if (cur[0])      nxt = '0;
            else                  nxt = cur + ONE;
        end else begin
            if (cur == '0)            nxt = TOP_C;
            else if (cur <= TOP_C)    nxt = cur - ONE;
            else if (cur == FIRST_X)  nxt = TOP_C;
            else                      nxt = cur - TWO;
        end
    end
endmodule

// File: rtl/bcd_term.sv
// Active-low terminal-count carry: low when counting is enabled and the
// digit sits at the last code of the current direction.
module bcd_term #(
    parameter int W        = 4,
    parameter int TOP_CODE = 9
) (
    input  logic [W-1:0] cur,
    input  logic         up,
    input  logic         cin_n,
    output logic         cout_n
);
    localparam logic [W-1:0] TOP_C = W'(TOP_CODE);

    logic at_end;

    // Terminal code depends on direction.
    always_comb at_end = up ? (cur == TOP_C) : (cur == '0);

    // Carry only propagates while this digit is itself enabled.
    always_comb cout_n = ~(at_end & ~cin_n);
endmodule

// File: rtl/bcd_updown_counter.sv
// One decimal digit up/down counter with clear, parallel load and
// active-low carry chaining. Clear (clr_n) is the synchronous active-low
// reset; all actions take effect on the rising edge of clk.
module bcd_updown_counter
    import bcd_cnt_pkg::*;
#(
    parameter int DIGIT_W  = 4,
    parameter int TOP_CODE = 9
) (
    input  logic               clk,
    input  logic               clr_n,
    input  logic               load,
    input  logic [DIGIT_W-1:0] jam,
    input  logic               up,
    input  logic               cin_n,
    output logic [DIGIT_W-1:0] q,
    output logic               cout_n
);
    localparam logic [DIGIT_W-1:0] TOP_C = DIGIT_W'(TOP_CODE);

    act_e               act;
    logic [DIGIT_W-1:0] step_val;
    logic [DIGIT_W-1:0] cnt_q;

    bcd_act_sel u_sel (
        .clr_n (clr_n),
        .load  (load),
        .cin_n (cin_n),
        .act   (act)
    );

    bcd_step #(.W(DIGIT_W), .TOP_CODE(TOP_CODE)) u_step (
        .cur (cnt_q),
        .up  (up),
        .nxt (step_val)
    );

    bcd_term #(.W(DIGIT_W), .TOP_CODE(TOP_CODE)) u_term (
        .cur    (cnt_q),
        .up     (up),
        .cin_n  (cin_n),
        .cout_n (cout_n)
    );

    // Digit register: apply the selected action.
    always_ff @(posedge clk) begin
        case (act)
            ACT_CLEAR: cnt_q <= '0;
            ACT_LOAD:  cnt_q <= jam;
            ACT_COUNT: cnt_q <= step_val;
            default:   cnt_q <= cnt_q;
        endcase
    end

    always_comb q = cnt_q;

    // Disabled count keeps the digit (R1).
    p_hold_r1: assert property (@(posedge clk) disable iff (!clr_n)
        (!load && cin_n) |=> $stable(q));

    // A legal digit stays legal while counting or holding (R2, R3).
    p_legal_r2: assert property (@(posedge clk) disable iff (!clr_n)
        (!load && q <= TOP_C) |=> q <= TOP_C);

    // Load wins over count-enable and direction (R5).
    p_load_r5: assert property (@(posedge clk) disable iff (!clr_n)
        load |=> q == $past(jam));

    // Up recovery: even illegal codes step up by one (R6).
    p_rec_even_r6: assert property (@(posedge clk) disable iff (!clr_n)
        (!load && !cin_n && up && q > TOP_C && !q[0]) |=> q == $past(q) + 1'b1);

    // Up recovery: odd illegal codes fall to zero (R6).
    p_rec_odd_r6: assert property (@(posedge clk) disable iff (!clr_n)
        (!load && !cin_n && up && q > TOP_C && q[0]) |=> q == '0);

    // Down recovery always moves toward the legal range (R7).
    p_rec_dn_r7: assert property (@(posedge clk) disable iff (!clr_n)
        (!load && !cin_n && !up && q > TOP_C) |=> q < $past(q));

    // A low carry while counting up predicts the wrap to zero (R8).
    p_carry_wrap_r8: assert property (@(posedge clk) disable iff (!clr_n)
        (!load && up && !cout_n) |=> q == '0);
endmodule

// File: tb/bcd_updown_counter_test.sv
module bcd_updown_counter_test;
    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       load = 1'b0;
    logic [3:0] jam = 4'd0;
    logic       up = 1'b1;
    logic       cin_n = 1'b1;
    logic [3:0] q;
    logic       cout_n;
    logic       load_hi = 1'b0;
    logic [3:0] jam_hi = 4'd0;
    logic [3:0] q_hi;
    logic       cout_hi_n;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    bcd_updown_counter uut (
        .clk(clk), .clr_n(clr_n), .load(load), .jam(jam), .up(up),
        .cin_n(cin_n), .q(q), .cout_n(cout_n)
    );

    // Tens digit, chained from the units digit for the cascade test.
    bcd_updown_counter uut_tens (
        .clk(clk), .clr_n(clr_n), .load(load_hi), .jam(jam_hi), .up(up),
        .cin_n(cout_n), .q(q_hi), .cout_n(cout_hi_n)
    );

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int nxt_up(int v);
        case (v)
            9, 11, 13, 15: return 0;
            default:       return v + 1;
        endcase
    endfunction

    function automatic int nxt_dn(int v);
        case (v)
            0, 10, 11: return 9;
            12: return 10;
            13: return 11;
            14: return 12;
            15: return 13;
            default: return v - 1;
        endcase
    endfunction

    task automatic t_clear();
        clr_n = 1'b0; load = 1'b1; jam = 4'd5; cin_n = 1'b0; up = 1'b1;
        step();
        chk("R4 clear beats load", q, 0);
        load = 1'b0; jam = 4'd0;
        step();
        chk("R4 clear beats count", q, 0);
        #1;
        chk("R8 cout high at 0 counting up", cout_n, 1);
    endtask

    task automatic t_up();
        clr_n = 1'b1; load = 1'b0; up = 1'b1; cin_n = 1'b0;
        for (int i = 1; i <= 12; i++) begin
            if (q == 4'd9) chk("R8 cout low at 9 up", cout_n, 0);
            else           chk("R8 cout high off terminal", cout_n, 1);
            step();
            chk("R2 count up", q, i % 10);
        end
    endtask

    task automatic t_down();
        int exp = q;
        up = 1'b0; cin_n = 1'b0; #1;
        for (int i = 0; i < 13; i++) begin
            if (exp == 0) chk("R8 cout low at 0 down", cout_n, 0);
            step();
            exp = (exp == 0) ? 9 : exp - 1;
            chk("R3 count down", q, exp);
        end
    endtask

    task automatic t_hold();
        int held = q;
        cin_n = 1'b1; up = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R1 hold with cin_n high", q, held);
        end
        load = 1'b1; jam = 4'd9; step(); load = 1'b0; #1;
        chk("R8 cout high when cin_n high", cout_n, 1);
        step();
        chk("R1 hold at 9", q, 9);
    endtask

    task automatic t_load();
        cin_n = 1'b1; up = 1'b1; load = 1'b1; jam = 4'd7;
        step();
        chk("R5 load with count disabled", q, 7);
        cin_n = 1'b0; up = 1'b0; jam = 4'd3;
        step();
        chk("R5 load beats count down", q, 3);
        up = 1'b1; jam = 4'd12;
        step();
        chk("R5 load of illegal code", q, 12);
        load = 1'b0;
    endtask

    task automatic t_rec_up();
        for (int v = 10; v < 16; v++) begin
            int exp = v;
            load = 1'b1; jam = 4'(v); cin_n = 1'b1; step();
            load = 1'b0; cin_n = 1'b0; up = 1'b1;
            for (int n = 0; n < 2; n++) begin
                step();
                exp = nxt_up(exp);
                chk("R6 up recovery path", q, exp);
            end
            chk("R6 legal within 2", int'(q <= 4'd9), 1);
        end
    endtask

    task automatic t_rec_dn();
        for (int v = 10; v < 16; v++) begin
            int exp = v;
            load = 1'b1; jam = 4'(v); cin_n = 1'b1; step();
            load = 1'b0; cin_n = 1'b0; up = 1'b0;
            for (int n = 0; n < 4; n++) begin
                step();
                exp = nxt_dn(exp);
                chk("R7 down recovery path", q, exp);
            end
            chk("R7 legal within 4", int'(q <= 4'd9), 1);
        end
    endtask

    task automatic t_cascade();
        clr_n = 1'b0; step(); clr_n = 1'b1;
        up = 1'b1; cin_n = 1'b0;
        for (int k = 1; k <= 23; k++) begin
            step();
            chk("R9 cascade up", int'(q_hi) * 10 + int'(q), k);
        end
        up = 1'b0;
        for (int k = 22; k >= 0; k--) begin
            step();
            chk("R9 cascade down", int'(q_hi) * 10 + int'(q), k);
        end
        step();
        chk("R9 cascade 00 to 99", int'(q_hi) * 10 + int'(q), 99);
        cin_n = 1'b1;
    endtask

    initial begin
        #(4 * 5000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #1;
        t_clear();
        t_up();
        t_down();
        t_hold();
        t_load();
        t_rec_up();
        t_rec_dn();
        t_cascade();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule